// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the host-side register file of a four-channel DMA controller in the classic byte-wide I/O style. The host reaches it over an 8-bit bus with a chip select, a 4-bit port number and single-cycle read and write strobes. Each channel holds a 16-bit current address and a 16-bit current count. All of these 16-bit registers share one byte-pointer flip-flop and go through byte-wide ports, low byte first. Per-channel mode registers, per-channel mask bits and one command register complete the host-visible state.

A separate transfer engine drives a step strobe with a channel number. A step on an unmasked channel advances that channel's address by one and lowers its count by one. The count holds the transfer length minus one. When a step finds the count at zero, the count wraps to 0xFFFF, the channel's terminal-count flag rises and its mask bit is set. Each channel's request-enable output is high only while the channel is unmasked and its mode is not cascade.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four mask bits are set, every request enable and terminal-count flag is low, the byte pointer selects the low byte, and the command register, addresses, counts and modes are zero.
- R2: Port 2n writes channel n's address and port 2n+1 writes its count, one byte per access, low byte while the pointer is low and high byte while it is high. One pointer is shared by all eight ports and toggles on every read or write to any of them.
- R3: A read of port 2n or 2n+1 returns the low or high byte of the current value by the same shared pointer. Writing 0x55 then 0xAA and reading back after a pointer clear returns 0x55 then 0xAA.
- R4: A write of any value to port 0xC sets the pointer low, so the next 16-bit access reaches the low byte.
- R5: A write to port 0xA selects channel data[1:0]. It sets that channel's mask bit when data[2]=1 and clears it when data[2]=0.
- R6: A write to port 0xB stores data[7:2] as the 6-bit mode of channel data[1:0], shown on that channel's slice of chan_mode. Mode bits [5:4] (data[7:6]) equal to 2'b11 mean cascade.
- R7: chan_enable[n] is high exactly when channel n is unmasked and its mode bits [5:4] are not 2'b11.
- R8: A write to port 0x8 stores the command byte (0x10 included), and a read of port 0x8 returns it. Reads of ports 0x9 to 0xF return 0.
- R9: A write of any value to port 0xD sets the pointer low, clears the command register and all terminal-count flags, and sets all four mask bits.
- R10: A step on an unmasked channel raises its address by one and lowers its count by one at the next clock edge. A step on a masked channel changes nothing.
- R11: A step at count zero wraps the count to 0xFFFF, sets the channel's terminal-count flag and sets its mask bit. A write to that channel's count port clears the flag.
- R12: Strobes with sel low have no effect on any register or on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| addr | input | 4 | Port number |
| wr_data | input | 8 | Write data byte |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 8 | Read data, valid while rd_stb is high |
| step | input | 1 | Transfer-engine step strobe |
| step_chan | input | 2 | Channel addressed by step |
| chan_enable | output | 4 | Per-channel request enable |
| chan_mode | output | 24 | Mode of channel n at bits [6n+5:6n] |
| chan_addr | output | 64 | Current address of channel n at bits [16n+15:16n] |
| chan_count | output | 64 | Current count of channel n at bits [16n+15:16n] |
| tc_flag | output | 4 | Per-channel terminal-count flag |

## Verification
The hardest state to reach from the ports is the count wrap. To get there, a channel's count is loaded with 1 and the channel is unmasked by a single-mask write, then two steps are issued. The second step has to raise the flag, mask the channel and lower its enable, and a third step must then leave the address alone. The shared pointer is a second trap, and the bench reaches it by leaving the pointer high after a write to one port and reading a different port, which must return the high byte.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int REG_W  = 16;
  localparam int MODE_W = 6;

  localparam logic [3:0] PORT_CMD    = 4'h8;
  localparam logic [3:0] PORT_MASK   = 4'hA;
  localparam logic [3:0] PORT_MODE   = 4'hB;
  localparam logic [3:0] PORT_CLRPTR = 4'hC;
  localparam logic [3:0] PORT_MCLR   = 4'hD;

  localparam logic [1:0] XFER_CASCADE = 2'b11;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_addr,
  input  logic             ld_cnt,
  input  logic             ptr_hi,
  input  logic [7:0]       wdata,
  input  logic             step,
  input  logic             clr,
  output logic [REG_W-1:0] cur_addr,
  output logic [REG_W-1:0] cur_cnt,
  output logic             tc_flag,
  output logic             tc_pulse
);
  logic [REG_W-1:0] addr_q, addr_d, cnt_q, cnt_d;
  logic             tc_q, tc_d;

  assign tc_pulse = step && (cnt_q == '0) && !ld_cnt;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    tc_d   = tc_q;
    if (ld_addr) begin
      if (ptr_hi) addr_d[15:8] = wdata;
      else        addr_d[7:0]  = wdata;
    end else if (step) begin
      addr_d = addr_q + 1'b1;
    end
    if (ld_cnt) begin
      if (ptr_hi) cnt_d[15:8] = wdata;
      else        cnt_d[7:0]  = wdata;
    end else if (step) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (clr || ld_cnt) tc_d = 1'b0;
    else if (tc_pulse) tc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      tc_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      tc_q   <= tc_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign tc_flag  = tc_q;

  // R10
  step_addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_addr) |=> (addr_q == $past(addr_q) + 1'b1));
  // R11
  wrap_sets_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_cnt && !clr && cnt_q == '0) |=> (tc_q && cnt_q == '1));
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic [3:0]          addr,
  input  logic [7:0]          wr_data,
  input  logic                wr_stb,
  input  logic                rd_stb,
  input  logic [NCH-1:0]      tc_pulse,
  output logic                ptr_hi,
  output logic                mclr,
  output logic [NCH-1:0]      mask,
  output logic [NCH*MODE_W-1:0] mode_flat,
  output logic [7:0]          cmd,
  output logic [NCH-1:0]      ld_addr,
  output logic [NCH-1:0]      ld_cnt
);
  logic wr_acc, rd_acc, chan_port, clrptr;
  logic ptr_q, ptr_d;
  logic [NCH-1:0] mask_q, mask_d;
  logic [MODE_W-1:0] mode_q [NCH];
  logic [MODE_W-1:0] mode_d [NCH];
  logic [7:0] cmd_q, cmd_d;
  logic [CH_W-1:0] wsel;

  assign wr_acc    = sel && wr_stb;
  assign rd_acc    = sel && rd_stb;
  assign chan_port = (addr < 4'(2*NCH));
  assign mclr      = wr_acc && (addr == PORT_MCLR);
  assign clrptr    = wr_acc && (addr == PORT_CLRPTR);
  assign wsel      = wr_data[CH_W-1:0];

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign ld_addr[n] = wr_acc && (addr == 4'(2*n));
    assign ld_cnt[n]  = wr_acc && (addr == 4'(2*n+1));
    assign mode_flat[n*MODE_W +: MODE_W] = mode_q[n];
  end

  always_comb begin
    ptr_d  = ptr_q;
    mask_d = mask_q | tc_pulse;
    cmd_d  = cmd_q;
    for (int n = 0; n < NCH; n++) mode_d[n] = mode_q[n];
    if (mclr || clrptr) ptr_d = 1'b0;
    else if ((wr_acc || rd_acc) && chan_port) ptr_d = !ptr_q;
    if (mclr) begin
      mask_d = '1;
      cmd_d  = '0;
    end else begin
      if (wr_acc && addr == PORT_MASK) mask_d[wsel] = wr_data[2];
      if (wr_acc && addr == PORT_MODE) mode_d[wsel] = wr_data[7:2];
      if (wr_acc && addr == PORT_CMD)  cmd_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      mask_q <= '1;
      cmd_q  <= '0;
      for (int n = 0; n < NCH; n++) mode_q[n] <= '0;
    end else begin
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
      cmd_q  <= cmd_d;
      for (int n = 0; n < NCH; n++) mode_q[n] <= mode_d[n];
    end
  end

  assign ptr_hi = ptr_q;
  assign mask   = mask_q;
  assign cmd    = cmd_q;

  // R9
  mclr_masks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_q == '1 && cmd_q == '0 && !ptr_q));
  // R4
  clrptr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clrptr |=> !ptr_q);
  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_acc || rd_acc) && chan_port) |=> (ptr_q != $past(ptr_q)));
  // R12
  idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ptr_q));
  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && addr == PORT_MASK) |=> (mask_q[$past(wsel)] == $past(wr_data[2])));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic [3:0]            addr,
  input  logic [7:0]            wr_data,
  input  logic                  wr_stb,
  input  logic                  rd_stb,
  output logic [7:0]            rd_data,
  input  logic                  step,
  input  logic [CH_W-1:0]       step_chan,
  output logic [NCH-1:0]        chan_enable,
  output logic [NCH*MODE_W-1:0] chan_mode,
  output logic [NCH*REG_W-1:0]  chan_addr,
  output logic [NCH*REG_W-1:0]  chan_count,
  output logic [NCH-1:0]        tc_flag
);
  logic ptr_hi, mclr;
  logic [NCH-1:0] mask, ld_addr, ld_cnt, tc_pulse, step_vec;
  logic [7:0] cmd;
  logic [REG_W-1:0] cur_addr [NCH];
  logic [REG_W-1:0] cur_cnt  [NCH];
  logic [CH_W-1:0] rsel;
  logic [REG_W-1:0] rword;

  dmac_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .addr      (addr),
    .wr_data   (wr_data),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .tc_pulse  (tc_pulse),
    .ptr_hi    (ptr_hi),
    .mclr      (mclr),
    .mask      (mask),
    .mode_flat (chan_mode),
    .cmd       (cmd),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    assign step_vec[n] = step && (step_chan == CH_W'(n)) && !mask[n];

    dmac_chan #(.REG_W(REG_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_addr  (ld_addr[n]),
      .ld_cnt   (ld_cnt[n]),
      .ptr_hi   (ptr_hi),
      .wdata    (wr_data),
      .step     (step_vec[n]),
      .clr      (mclr),
      .cur_addr (cur_addr[n]),
      .cur_cnt  (cur_cnt[n]),
      .tc_flag  (tc_flag[n]),
      .tc_pulse (tc_pulse[n])
    );

    assign chan_addr[n*REG_W +: REG_W]  = cur_addr[n];
    assign chan_count[n*REG_W +: REG_W] = cur_cnt[n];
    assign chan_enable[n] = !mask[n] &&
      (chan_mode[n*MODE_W + MODE_W-1 -: 2] != XFER_CASCADE);

    // R11
    tc_masks_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_flag[n]) |-> !chan_enable[n]);
    // R10
    masked_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && step_chan == CH_W'(n) && !chan_enable[n] && !ld_addr[n] &&
       chan_mode[n*MODE_W + MODE_W-1 -: 2] != XFER_CASCADE)
      |=> $stable(cur_addr[n]));
  end

  assign rsel  = addr[CH_W:1];
  assign rword = addr[0] ? cur_cnt[rsel] : cur_addr[rsel];

  always_comb begin
    rd_data = '0;
    if (addr < 4'(2*NCH)) rd_data = ptr_hi ? rword[15:8] : rword[7:0];
    else if (addr == PORT_CMD) rd_data = cmd;
  end
endmodule

// File: tb/dmac_regfile_tb_top.sv
module dmac_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, step = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] step_chan = '0;
  logic [7:0] rd_data;
  logic [3:0] chan_enable, tc_flag;
  logic [23:0] chan_mode;
  logic [63:0] chan_addr, chan_count;
  int checks = 0, fails = 0;

  always #10 clk = !clk;

  dmac_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_data(wr_data),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_data(rd_data), .step(step),
    .step_chan(step_chan), .chan_enable(chan_enable), .chan_mode(chan_mode),
    .chan_addr(chan_addr), .chan_count(chan_count), .tc_flag(tc_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [3:0] a, input logic [7:0] d, input logic s = 1'b1);
    @(negedge clk);
    sel = s; addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic io_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; addr = a; rd_stb = 1'b1;
    #5 d = rd_data;
    @(negedge clk);
    sel = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic do_step(input logic [1:0] ch);
    @(negedge clk);
    step = 1'b1; step_chan = ch;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 enables", chan_enable, 4'h0);
    check("R1 tc", tc_flag, 4'h0);
    check("R1 addr", chan_addr[31:0], 32'h0);
    check("R1 mode", chan_mode, 24'h0);
    io_rd(4'h8, d); check("R1 cmd", d, 8'h00);
    io_rd(4'h1, d); check("R1 pointer low", d, 8'h00);
  endtask

  task automatic t_bytes();
    logic [7:0] d;
    io_wr(4'hC, 8'h00);
    io_wr(4'h0, 8'h55); io_wr(4'h0, 8'hAA);
    check("R2 ch0 addr", chan_addr[15:0], 16'hAA55);
    io_wr(4'hC, 8'h5A);
    io_rd(4'h0, d); check("R3 low byte", d, 8'h55);
    io_rd(4'h0, d); check("R3 high byte", d, 8'hAA);
    io_wr(4'hC, 8'h00);
    io_wr(4'h3, 8'hCD); io_wr(4'h3, 8'hAB);
    check("R2 ch1 count", chan_count[31:16], 16'hABCD);
    io_wr(4'hC, 8'h00);
    io_wr(4'h2, 8'h11);
    io_rd(4'h3, d); check("R2 shared pointer high", d, 8'hAB);
    io_rd(4'h3, d); check("R3 shared pointer low", d, 8'hCD);
    io_wr(4'h2, 8'h22);
    io_wr(4'hC, 8'hFF);
    io_wr(4'h2, 8'h33);
    check("R4 clear pointer", chan_addr[31:16], 16'h2233);
  endtask

  task automatic t_mask_mode();
    io_wr(4'hB, 8'h42);
    check("R6 mode ch2", chan_mode[17:12], 6'h10);
    check("R7 masked", chan_enable[2], 1'b0);
    io_wr(4'hA, 8'h02);
    check("R5 unmask ch2", chan_enable, 4'h4);
    io_wr(4'hB, 8'hC3);
    check("R6 mode ch3", chan_mode[23:18], 6'h30);
    io_wr(4'hA, 8'h03);
    check("R7 cascade blocks enable", chan_enable, 4'h4);
    io_wr(4'hA, 8'h06);
    check("R5 mask ch2", chan_enable, 4'h0);
    io_wr(4'hA, 8'h02);
    check("R5 unmask again", chan_enable, 4'h4);
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    io_wr(4'h8, 8'h10);
    io_rd(4'h8, d); check("R8 cmd readback", d, 8'h10);
    io_rd(4'hE, d); check("R8 unused port", d, 8'h00);
  endtask

  task automatic t_step();
    logic [7:0] d;
    io_wr(4'hC, 8'h00);
    io_wr(4'h4, 8'h00); io_wr(4'h4, 8'h10);
    io_wr(4'h5, 8'h01); io_wr(4'h5, 8'h00);
    do_step(2'd2);
    check("R10 addr inc", chan_addr[47:32], 16'h1001);
    check("R10 count dec", chan_count[47:32], 16'h0000);
    check("R10 no tc yet", tc_flag, 4'h0);
    do_step(2'd2);
    check("R11 count wrap", chan_count[47:32], 16'hFFFF);
    check("R11 tc set", tc_flag, 4'h4);
    check("R11 masked on tc", chan_enable, 4'h0);
    io_rd(4'h5, d); check("R3 residue low", d, 8'hFF);
    io_rd(4'h5, d); check("R3 residue high", d, 8'hFF);
    do_step(2'd2);
    check("R10 masked step ignored", chan_addr[47:32], 16'h1002);
    do_step(2'd0);
    check("R10 masked ch0 ignored", chan_addr[15:0], 16'hAA55);
    io_wr(4'h5, 8'h07);
    check("R11 tc cleared by count write", tc_flag, 4'h0);
  endtask

  task automatic t_mclr();
    logic [7:0] d;
    io_wr(4'hA, 8'h01);
    io_wr(4'h0, 8'h00);
    io_wr(4'hD, 8'h00);
    check("R9 all masked", chan_enable, 4'h0);
    io_rd(4'h8, d); check("R9 cmd cleared", d, 8'h00);
    io_wr(4'h0, 8'h99);
    check("R9 pointer low", chan_addr[7:0], 8'h99);
  endtask

  task automatic t_nosel();
    logic [7:0] d;
    io_wr(4'hA, 8'h00, 1'b0);
    check("R12 mask unchanged", chan_enable, 4'h0);
    io_wr(4'h8, 8'h5A, 1'b0);
    io_rd(4'h8, d); check("R12 cmd unchanged", d, 8'h00);
    io_wr(4'h0, 8'h77, 1'b0);
    io_rd(4'h0, d); check("R12 pointer unchanged", d, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_mask_mode();
    t_cmd();
    t_step();
    t_mclr();
    t_nosel();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule